// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter

This block produces a periodic interrupt from a reloading down-counter. A free-running timer-clock enable (`tick_in`) is divided by a prescaler that divides by 4 or by 256. Each prescaled tick moves a 16-bit counter one step toward zero. When the counter lands on zero, a sticky pending flag is set, and an interrupt is raised if interrupts are enabled. On the following prescaled tick the counter reloads itself from a software-written reload register and counts down again, so the period is (reload + 1) prescaled ticks.

Software sees three registers through a plain write port and a combinational read port. Address 0 is control/status, address 1 is the reload value and address 2 is the current count, which is read-only. Writing the reload register stops the countdown in progress, clears the prescaler and starts counting from the new value on that same edge. A debug `freeze` input stops the prescaler and the counter without changing any register. The register port is a simple control interface with no back-pressure: a write is taken on every clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` in the same cycle.

Top module: `prd_irq_timer`

## Requirements
- R1: After reset, control/status reads 0, reload reads 0xFFFF, count reads 0xFFFF, `irq` is 0 and the prescaler phase is 0.
- R2: With run (control bit 0) set, the count drops by one on every prescaled tick. A prescaled tick comes every 4 `tick_in` cycles when select (control bit 2) is 0 and every 256 when it is 1. The first step comes 4 (or 256) active cycles after the prescaler is cleared.
- R3: On the tick that brings the count to zero, pending (control bit 7) is set on that same edge. `irq` equals pending ANDed with interrupt-enable (control bit 1).
- R4: On the prescaled tick after the count is zero, the counter loads the reload value and counting continues.
- R5: A write to address 1 loads that value into both the reload register and the counter on the write edge, and sets the prescaler phase back to 0.
- R6: Pending stays set across further expiries. It is cleared only by a control write with bit 7 equal to 1. A control write with bit 7 equal to 0 leaves it unchanged.
- R7: If a pending clear and an expiry fall on the same edge, pending ends up set.
- R8: With run at 0, both the counter and the prescaler phase hold their values. When run is set again, counting resumes from the held phase.
- R9: While `freeze` is 1, the counter and the prescaler phase hold.
- R10: Reading address 2 (count) has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Timer clock enable, one pulse per timer clock period |
| freeze | input | 1 | Debug halt for the prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control/status, 1 reload) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 control/status, 1 reload, 2 count) |
| rd_data | output | 16 | Read data for rd_addr |
| irq | output | 1 | Interrupt request, pending AND interrupt-enable |

## Verification
The collision that matters here is a software clear of the pending flag landing on the same edge as a counter expiry. The bench aligns a control write carrying the clear bit with the exact edge on which the count reaches zero. It then checks that `irq` is still high in the cycle after that edge. Clears on edges with no expiry, before and after the collision, show that a clear alone does take effect. A reload write landing mid-way through a prescaler phase is provoked in the same way, and the bench checks that no decrement appears where the old phase would have produced one.

// File: rtl/prd_timer_pkg.sv
package prd_timer_pkg;
  // register addresses
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // control/status bit positions
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_DSEL = 2;
  localparam int unsigned BIT_PEND = 7;
endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler #(
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic restart,
  input  logic dsel,
  output logic tick_out
);
  localparam int unsigned PRE_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [PRE_W-1:0] LIM_LO = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] LIM_HI = PRE_W'(DIV_HI - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             at_lim;

  assign lim      = dsel ? LIM_HI : LIM_LO;
  // >= so that a switch from the long to the short divisor cannot overrun
  assign at_lim   = (pre_q >= lim);
  assign tick_out = adv & ~restart & at_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (adv) begin
      pre_q <= at_lim ? '0 : pre_q + 1'b1;
    end
  end

  // R8 R9
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(pre_q));

  // R5
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/prd_counter.sv
module prd_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign cnt_nxt = at_zero ? reload_val : cnt_q - 1'b1;
  // expiry is the tick that lands the count on zero; a direct load does not count
  assign expire  = tick & ~load & (cnt_nxt == '0);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= cnt_nxt;
    end
  end

  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R4
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero) |=> (cnt_q == $past(reload_val)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8 R9 R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/prd_regs.sv
module prd_regs
  import prd_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [CNT_W-1:0] count,
  input  logic             expire,
  output logic             run,
  output logic             dsel,
  output logic [CNT_W-1:0] reload_val,
  output logic             load,
  output logic             irq
);
  logic             run_q, ien_q, dsel_q, pend_q;
  logic [CNT_W-1:0] reload_q;
  logic             ctrl_wr, clr;

  assign ctrl_wr = wr_en & (wr_addr == REG_CTRL);
  assign load    = wr_en & (wr_addr == REG_RELOAD);
  assign clr     = ctrl_wr & wr_data[BIT_PEND];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
      dsel_q   <= 1'b0;
      reload_q <= '1;
    end else begin
      if (ctrl_wr) begin
        run_q  <= wr_data[BIT_RUN];
        ien_q  <= wr_data[BIT_IEN];
        dsel_q <= wr_data[BIT_DSEL];
      end
      if (load) reload_q <= wr_data;
    end
  end

  // expiry outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (expire) pend_q <= 1'b1;
    else if (clr)    pend_q <= 1'b0;
  end

  assign run        = run_q;
  assign dsel       = dsel_q;
  assign reload_val = reload_q;
  assign irq        = pend_q & ien_q;

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_CTRL: begin
        rd_data[BIT_RUN]  = run_q;
        rd_data[BIT_IEN]  = ien_q;
        rd_data[BIT_DSEL] = dsel_q;
        rd_data[BIT_PEND] = pend_q;
      end
      REG_RELOAD: rd_data = reload_q;
      REG_COUNT:  rd_data = count;
      default:    rd_data = '0;
    endcase
  end

  // R3 R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q);

  // R6
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !pend_q);
endmodule

// File: rtl/prd_irq_timer.sv
module prd_irq_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             freeze,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic             run, dsel, load, adv, ptick, expire;
  logic [CNT_W-1:0] reload_val, count;

  assign adv = tick_in & run & ~freeze;

  prd_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv(adv), .restart(load),
    .dsel(dsel), .tick_out(ptick)
  );

  prd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(ptick), .load(load),
    .load_val(wr_data), .reload_val(reload_val),
    .cnt(count), .expire(expire)
  );

  prd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .expire(expire), .run(run), .dsel(dsel),
    .reload_val(reload_val), .load(load), .irq(irq)
  );

  // R9
  frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !ptick);
endmodule

// File: tb/sim_prd_irq_timer.sv
module sim_prd_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b1;
  logic        freeze = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd2;
  logic [15:0] rd_data;
  logic        irq;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int    at;
    int    kind;   // 0: irq, 1: rd_data
    int    val;
    string rq;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;   // 50 MHz

  prd_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .freeze(freeze),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expected item due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        int act;
        act = (q[i].kind == 0) ? int'(irq) : int'(rd_data);
        n_chk++;
        if (act !== q[i].val) begin
          n_bad++;
          $display("FAIL %s cyc %0d kind %0d actual %h expected %h",
                   q[i].rq, cyc, q[i].kind, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic exp(input int at, input int kind, input int val, input string rq);
    exp_t e;
    e.at = at; e.kind = kind; e.val = val; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic at_edge(input int e);
    while (cyc < e) begin
      @(posedge clk);
      #1;
    end
  endtask

  // write lands on edge `target`
  task automatic wr_at(input int target, input logic [1:0] a, input logic [15:0] d);
    if (cyc > target - 1) begin
      n_chk++; n_bad++;
      $display("FAIL schedule write target %0d actual %0d expected %0d", target, cyc, target - 1);
    end
    at_edge(target - 1);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_at(input int e, input logic [1:0] a);
    at_edge(e);
    rd_addr = a;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual expired expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    int w, w2;
    at_edge(5);
    rst_n = 1'b1;
    // R1 reset state
    exp(6, 1, 16'hFFFF, "R1");
    exp(6, 0, 0, "R1");
    rd_at(7, 2'd0); exp(7, 1, 0, "R1");
    rd_at(8, 2'd1); exp(8, 1, 16'hFFFF, "R1");
    rd_at(9, 2'd2); exp(9, 1, 16'hFFFF, "R1");

    wr_at(10, 2'd0, 16'h0003);   // run + ien, divide by 4
    w = 11;
    // R2 R3 R4 R5 R10
    exp(w,      1, 3, "R5");
    exp(w + 3,  1, 3, "R2");
    exp(w + 4,  1, 2, "R2");
    exp(w + 11, 0, 0, "R3");
    exp(w + 12, 1, 0, "R3");
    exp(w + 12, 0, 1, "R3");
    exp(w + 16, 1, 3, "R4");
    exp(w + 19, 0, 1, "R6");
    exp(w + 20, 0, 0, "R6");
    exp(w + 28, 0, 1, "R3");
    exp(w + 44, 0, 1, "R7");
    exp(w + 46, 0, 0, "R6");
    exp(w + 60, 0, 0, "R3");
    exp(w + 61, 1, 16'h0081, "R6");
    exp(w + 80, 1, 3, "R8");
    exp(w + 81, 0, 0, "R6");
    exp(w + 82, 1, 3, "R8");
    exp(w + 83, 1, 2, "R8");
    exp(w + 99, 1, 2, "R9");
    exp(w + 102, 1, 2, "R9");
    exp(w + 103, 1, 1, "R9");
    exp(w + 105, 1, 5, "R5");
    exp(w + 107, 1, 5, "R5");
    exp(w + 108, 1, 5, "R5");
    exp(w + 109, 1, 4, "R5");
    wr_at(w, 2'd1, 16'd3);
    wr_at(w + 20, 2'd0, 16'h0083);   // clear with no expiry
    wr_at(w + 44, 2'd0, 16'h0083);   // clear on the expiry edge
    wr_at(w + 46, 2'd0, 16'h0083);
    wr_at(w + 47, 2'd0, 16'h0001);   // ien off
    rd_at(w + 61, 2'd0);
    rd_at(w + 62, 2'd2);
    wr_at(w + 66, 2'd0, 16'h0000);   // run off, pending kept
    wr_at(w + 81, 2'd0, 16'h0083);
    at_edge(w + 83); freeze = 1'b1;
    at_edge(w + 99); freeze = 1'b0;
    wr_at(w + 105, 2'd1, 16'd5);     // mid-phase reload
    wr_at(w + 110, 2'd0, 16'h0007);  // divide by 256
    w2 = w + 111;
    exp(w2,       1, 1, "R5");
    exp(w2 + 255, 1, 1, "R2");
    exp(w2 + 255, 0, 0, "R2");
    exp(w2 + 256, 1, 0, "R2");
    exp(w2 + 256, 0, 1, "R3");
    exp(w2 + 512, 1, 1, "R4");
    exp(w2 + 512, 0, 1, "R6");
    wr_at(w2, 2'd1, 16'd1);
    at_edge(w2 + 514);
    foreach (q[i]) begin
      n_chk++; n_bad++;
      $display("FAIL %s cyc %0d actual unchecked expected checked", q[i].rq, q[i].at);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule